// File: doc/BRIEF.md
# Receive Frame Admission and Miss Counting

This block runs once for every incoming frame that the destination address filter has accepted. It looks at whether the host has handed over the current receive descriptor. It then reaches one of three outcomes: the frame is admitted to a host buffer, held in on-chip frame storage, or missed. When the cached ownership bit says no buffer is available, the block makes one last ownership poll of the current descriptor before it gives up on the frame.

After a frame is admitted, the block polls the next descriptor. After a miss, it makes no further polls until the dropped frame has ended. Each missed frame sets a sticky flag and advances a wrapping counter, and the host clears both with a single pulse.

When the storage size input is nonzero, a frame that finds no owned descriptor is queued without any poll. While the storage is in overflow, frames are missed instead. Overflow ends once the storage reports empty.

Top module: `rx_admit`

## Requirements
- R1: A `frm_start` pulse with `frm_accept` low produces no poll, no outcome pulse, and no change to `miss_cnt` or `miss_flag`.
- R2: An accepted frame with `cur_own` high gives an `admit_o` pulse in the cycle after `frm_start`. It causes no poll with `poll_idx`=0 and exactly one poll with `poll_idx`=1 (next descriptor).
- R3: With `q_size`=0, an accepted frame with `cur_own` low raises `poll_req` with `poll_idx`=0 (current descriptor) exactly once.
- R4: If that final poll returns `poll_own` high, `admit_o` pulses in the cycle after `poll_done`, and exactly one next-descriptor poll follows.
- R5: If the final poll returns `poll_own` low, `miss_o` pulses in the cycle after `poll_done`. `miss_flag` is set and `miss_cnt` rises by one.
- R6: After a miss, no poll of any kind is issued until `frm_end` has been seen for that frame.
- R7: With `q_size` nonzero and no overflow, an accepted frame with `cur_own` low gives a `queue_o` pulse and issues no poll.
- R8: With `q_size` nonzero, a `q_full` pulse enters overflow. During overflow, frames with `cur_own` low are missed with no poll and are counted by R5's counter. A `q_empty` pulse leaves overflow.
- R9: `miss_cnt` is `CNT_W` bits wide (default 16) and wraps from all ones to zero.
- R10: A `miss_clr` pulse clears `miss_cnt` to 0 and `miss_flag` to 0.
- R11: After reset, `miss_cnt` is 0, `miss_flag` is 0, `poll_req` is low, and no outcome pulse is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frm_start | input | 1 | Address decision made for a new frame |
| frm_accept | input | 1 | Address filter verdict, valid with frm_start |
| frm_end | input | 1 | Incoming frame has finished |
| cur_own | input | 1 | Cached ownership of the current descriptor |
| poll_done | input | 1 | Requested descriptor read completed |
| poll_own | input | 1 | Ownership bit returned by the poll |
| q_size | input | QSZ_W | On-chip frame storage size, 0 disables queuing |
| q_full | input | 1 | Frame storage overflowed |
| q_empty | input | 1 | Frame storage drained |
| miss_clr | input | 1 | Host clear of flag and counter |
| poll_req | output | 1 | Descriptor poll request |
| poll_idx | output | 1 | 0 = current descriptor, 1 = next descriptor |
| admit_o | output | 1 | Frame admitted to a host buffer |
| queue_o | output | 1 | Frame held in on-chip storage |
| miss_o | output | 1 | Frame missed |
| miss_flag | output | 1 | Sticky miss indication |
| miss_cnt | output | CNT_W | Missed-frame count |

## Verification
Frames are driven with every combination of filter verdict, cached ownership and final-poll answer, in both storage modes and in and out of overflow. A scoreboard pairs each frame with the one outcome pulse it expects. This separates admission through the cached bit from admission through the final poll and from a miss. The number of current-descriptor and next-descriptor polls is counted per frame, which exposes a missing final poll, a repeated final poll and any poll during a dropped frame. A second instance with a 4-bit counter shares the stimulus, so its wrap can be compared with the full-width count.

// File: rtl/rx_admit.sv
module rx_admit #(
  parameter int CNT_W = 16,
  parameter int QSZ_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frm_start,
  input  logic             frm_accept,
  input  logic             frm_end,
  input  logic             cur_own,
  input  logic             poll_done,
  input  logic             poll_own,
  input  logic [QSZ_W-1:0] q_size,
  input  logic             q_full,
  input  logic             q_empty,
  input  logic             miss_clr,
  output logic             poll_req,
  output logic             poll_idx,
  output logic             admit_o,
  output logic             queue_o,
  output logic             miss_o,
  output logic             miss_flag,
  output logic [CNT_W-1:0] miss_cnt
);

  typedef enum logic [1:0] {S_IDLE, S_FINAL, S_NEXT, S_DRAIN} st_t;
  st_t st, st_n;
  logic ovf, ended, q_on, start_ok, fin_hit, fin_miss;
  logic admit_ev, queue_ev, miss_ev;

  assign q_on     = |q_size;
  assign start_ok = (st == S_IDLE) && frm_start && frm_accept;
  assign fin_hit  = (st == S_FINAL) && poll_done && poll_own;
  assign fin_miss = (st == S_FINAL) && poll_done && !poll_own;
  assign admit_ev = (start_ok && cur_own) || fin_hit;
  assign queue_ev = start_ok && !cur_own && q_on && !ovf;
  assign miss_ev  = (start_ok && !cur_own && q_on && ovf) || fin_miss;
  assign poll_req = (st == S_FINAL) || (st == S_NEXT);
  assign poll_idx = (st == S_NEXT);

  always_comb begin
    st_n = st;
    case (st)
      S_IDLE:  if (start_ok) st_n = cur_own ? S_NEXT : (q_on ? S_DRAIN : S_FINAL);
      S_FINAL: if (poll_done) st_n = poll_own ? S_NEXT : S_DRAIN;
      S_NEXT:  if (poll_done) st_n = S_DRAIN;
      S_DRAIN: if (frm_end || ended) st_n = S_IDLE;
      default: st_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      ovf       <= 1'b0;
      ended     <= 1'b0;
      admit_o   <= 1'b0;
      queue_o   <= 1'b0;
      miss_o    <= 1'b0;
      miss_flag <= 1'b0;
      miss_cnt  <= '0;
    end else begin
      st      <= st_n;
      admit_o <= admit_ev;
      queue_o <= queue_ev;
      miss_o  <= miss_ev;
      if (st == S_IDLE) ended <= 1'b0;
      else if (frm_end) ended <= 1'b1;
      if (!q_on)        ovf <= 1'b0;
      else if (q_full)  ovf <= 1'b1;
      else if (q_empty) ovf <= 1'b0;
      if (miss_clr) begin
        miss_flag <= 1'b0;
        miss_cnt  <= '0;
      end else if (miss_ev) begin
        miss_flag <= 1'b1;
        miss_cnt  <= miss_cnt + 1'b1;
      end
    end
  end

  AST_REJECT_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == S_IDLE) && frm_start && !frm_accept) |=> (!admit_o && !queue_o && !miss_o && !poll_req)); // R1
  AST_ADMIT_THEN_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    admit_o |-> (poll_req && poll_idx)); // R2
  AST_MISS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    miss_o |-> (!poll_req && (miss_flag || $past(miss_clr)))); // R6
  AST_QUEUE_NO_POLL: assert property (@(posedge clk) disable iff (!rst_n)
    queue_o |-> !poll_req); // R7
  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({admit_o, queue_o, miss_o})); // R5
  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!miss_ev && !miss_clr) |=> $stable(miss_cnt)); // R9
  AST_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    miss_clr |=> (miss_cnt == '0 && !miss_flag)); // R10

endmodule

// File: tb/test_rx_admit.sv
`timescale 1ns/1ps
module test_rx_admit;
  logic clk = 1'b0, rst_n = 1'b0;
  logic frm_start = 0, frm_accept = 0, frm_end = 0, cur_own = 0;
  logic poll_done = 0, poll_own = 0, q_full = 0, q_empty = 0, miss_clr = 0;
  logic [7:0] q_size = 8'd0;
  logic poll_req, poll_idx, admit_o, queue_o, miss_o, miss_flag;
  logic [15:0] miss_cnt;
  logic s_req, s_idx, s_adm, s_que, s_mis, s_flag;
  logic [3:0] s_cnt;

  int nchk = 0, nfail = 0, p0 = 0, p1 = 0;
  bit fin_own = 0, done = 0;
  int exp_q[$];

  always #4 clk = ~clk;

  rx_admit i_rx_admit (.clk, .rst_n, .frm_start, .frm_accept, .frm_end, .cur_own,
    .poll_done, .poll_own, .q_size, .q_full, .q_empty, .miss_clr, .poll_req, .poll_idx,
    .admit_o, .queue_o, .miss_o, .miss_flag, .miss_cnt);

  rx_admit #(.CNT_W(4)) i_rx_admit_w4 (.clk, .rst_n, .frm_start, .frm_accept, .frm_end,
    .cur_own, .poll_done, .poll_own, .q_size, .q_full, .q_empty, .miss_clr,
    .poll_req(s_req), .poll_idx(s_idx), .admit_o(s_adm), .queue_o(s_que), .miss_o(s_mis),
    .miss_flag(s_flag), .miss_cnt(s_cnt));

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // poll responder: answers current-descriptor polls with fin_own, next with 1
  initial forever begin
    @(negedge clk);
    if (poll_req) begin
      if (poll_idx) p1++; else p0++;
      @(negedge clk);
      poll_done = 1'b1;
      poll_own  = poll_idx ? 1'b1 : fin_own;
      @(negedge clk);
      poll_done = 1'b0;
    end
  end

  // monitor: 0 admit, 1 queue, 2 miss
  initial forever begin
    @(negedge clk);
    if (admit_o || queue_o || miss_o) begin
      automatic int got = admit_o ? 0 : (queue_o ? 1 : 2);
      if (exp_q.size() == 0) chk(0, "R1", "unexpected outcome", got, -1);
      else begin
        automatic int e = exp_q.pop_front();
        chk(got == e, e == 0 ? "R2" : (e == 1 ? "R7" : "R5"), "outcome", got, e);
      end
    end
  end

  task automatic run_frame(input bit acc, input bit cown, input bit fown, input int exp,
                           input int e0, input int e1, input string req);
    cur_own = cown; fin_own = fown; p0 = 0; p1 = 0;
    if (exp >= 0) exp_q.push_back(exp);
    @(negedge clk); frm_start = 1; frm_accept = acc;
    @(negedge clk); frm_start = 0; frm_accept = 0;
    repeat (12) @(negedge clk);
    frm_end = 1;
    @(negedge clk); frm_end = 0;
    @(negedge clk);
    chk(p0 == e0, req, "current polls", p0, e0);
    chk(p1 == e1, req, "next polls", p1, e1);
    chk(exp_q.size() == 0, req, "pending outcomes", exp_q.size(), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(miss_cnt == 0 && !miss_flag, "R11", "reset counter/flag", miss_cnt, 0);
    chk(!poll_req && !admit_o && !queue_o && !miss_o, "R11", "reset outputs", poll_req, 0);

    run_frame(0, 0, 0, -1, 0, 0, "R1");
    chk(miss_cnt == 0 && !miss_flag, "R1", "reject leaves count", miss_cnt, 0);
    run_frame(1, 1, 0, 0, 0, 1, "R2");
    run_frame(1, 0, 1, 0, 1, 1, "R4");
    run_frame(1, 0, 0, 2, 1, 0, "R3");
    chk(miss_cnt == 1, "R5", "count after miss", miss_cnt, 1);
    chk(miss_flag == 1, "R5", "flag after miss", miss_flag, 1);
    // R6: the miss frame above saw exactly one current poll and no next poll
    run_frame(1, 0, 0, 2, 1, 0, "R6");
    chk(miss_cnt == 2, "R5", "count second miss", miss_cnt, 2);

    @(negedge clk); miss_clr = 1;
    @(negedge clk); miss_clr = 0;
    chk(miss_cnt == 0, "R10", "count after clear", miss_cnt, 0);
    chk(miss_flag == 0, "R10", "flag after clear", miss_flag, 0);

    q_size = 8'd4;
    run_frame(1, 0, 0, 1, 0, 0, "R7");
    run_frame(1, 1, 0, 0, 0, 1, "R2");
    @(negedge clk); q_full = 1;
    @(negedge clk); q_full = 0;
    run_frame(1, 0, 1, 2, 0, 0, "R8");
    chk(miss_cnt == 1, "R8", "overflow miss counted", miss_cnt, 1);
    run_frame(0, 0, 1, -1, 0, 0, "R1");
    chk(miss_cnt == 1, "R1", "reject in overflow", miss_cnt, 1);
    @(negedge clk); q_empty = 1;
    @(negedge clk); q_empty = 0;
    run_frame(1, 0, 0, 1, 0, 0, "R8");

    @(negedge clk); q_full = 1;
    @(negedge clk); q_full = 0;
    for (int k = 0; k < 19; k++) run_frame(1, 0, 0, 2, 0, 0, "R9");
    chk(miss_cnt == 20, "R9", "wide count", miss_cnt, 20);
    chk(s_cnt == 4'd4, "R9", "narrow counter wrapped", s_cnt, 4);
    chk(s_flag == 1, "R9", "narrow flag", s_flag, 1);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule